// File: doc/BRIEF.md
# Execute Redirect Squash Generator

This block sits after the execute lanes of an out-of-order core. Each cycle it looks at up to `LANES` executed instructions, listed oldest first, and decides per hardware thread whether that thread has to be redirected. When it has to be, the block builds one squash message for the retirement logic. The message holds the sequence number to squash from, the PC to restart fetch at, the PC of the offending instruction, a taken flag for branches, and a flag that says whether the offending instruction itself is squashed.

There are three causes, ranked. A mispredicted branch restarts at its resolved next PC and keeps itself. A pending memory-order violation on the thread restarts at the next PC of the instruction that sees it, keeps that instruction, and consumes the violation. A load of the thread whose memory access is blocked, when that block has not been handled yet, restarts at the load's own PC and squashes the load too. It also pulses a handled indication so that the same block does not squash again.

Only the first redirect of each thread in a cycle counts, which is also the oldest. Two counters record honoured mispredictions, split by predicted direction, and a third port gives their sum.

Top module: `exec_redirect_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every `sq_vld` bit is 0, all squash fields are 0, all counters are 0 and no violation is pending.
- R2: A valid lane with `lane_mispred`=1 produces, on the next clock edge, `sq_vld`=1 for its thread with `sq_seq` = the lane's sequence number, `sq_restart_pc` = its next PC, `sq_mis_pc` = its PC and `sq_incl_self`=0.
- R3: For a branch squash, `sq_taken` is 1 exactly when next PC != PC + `INST_BYTES` (default 4). For the other two causes `sq_taken` is 0.
- R4: A pulse on `viol_set[t]` makes a violation pending for thread t from the next cycle on. The first valid non-mispredicted lane of thread t then produces a squash with restart PC = its next PC and `sq_incl_self`=0, and this clears the pending violation. A violation that arrives in the same cycle as it is consumed stays pending.
- R5: A valid lane with `lane_is_load`=1 whose thread has `ld_blocked`=1 and `ld_handled`=0 produces a squash with restart PC = its own PC and `sq_incl_self`=1, and pulses `ld_handled_set[t]` together with that squash. If `ld_handled` is 1, or the lane is not a load, nothing happens.
- R6: After a thread's first redirecting lane in a cycle, its later lanes in that cycle have no effect: no message fields, no counter change and no consumption of a pending violation. The lanes are ordered oldest first, lane 0 being the oldest.
- R7: Within one lane the ranking is mispredict, then pending violation, then blocked load. A violation that loses to a mispredict stays pending.
- R8: Each honoured mispredict adds 1 to `cnt_tkn_wrong` if `lane_pred_tkn`=1 and to `cnt_ntkn_wrong` if not. `cnt_mispred` equals their sum.
- R9: Threads are independent, so several threads can be squashed in the same cycle.
- R10: The message is valid for one cycle only. In a cycle with no redirect for a thread, its `sq_vld`, `sq_taken`, `sq_incl_self`, `ld_handled_set`, sequence and PC fields are all 0.
- R11: Lanes with `lane_vld`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_vld | input | LANES | Lane holds an executed instruction |
| lane_mispred | input | LANES | Branch resolved as mispredicted |
| lane_pred_tkn | input | LANES | Branch had been predicted taken |
| lane_is_load | input | LANES | Instruction is a load |
| lane_tid | input | LANES*TID_W | Thread id per lane |
| lane_pc | input | LANES*PC_W | Instruction PC per lane |
| lane_npc | input | LANES*PC_W | Resolved next PC per lane |
| lane_seq | input | LANES*SEQ_W | Sequence number per lane |
| viol_set | input | THREADS | Memory-order violation detected for the thread |
| ld_blocked | input | THREADS | Thread has a load blocked by memory |
| ld_handled | input | THREADS | The blocked load was already handled |
| sq_vld | output | THREADS | Squash message valid |
| sq_seq | output | THREADS*SEQ_W | Sequence number to squash from |
| sq_restart_pc | output | THREADS*PC_W | Fetch restart PC |
| sq_mis_pc | output | THREADS*PC_W | PC of the offending instruction |
| sq_taken | output | THREADS | Mispredicted branch was actually taken |
| sq_incl_self | output | THREADS | Offending instruction is squashed too |
| ld_handled_set | output | THREADS | Marks the blocked load as handled |
| cnt_tkn_wrong | output | CNT_W | Mispredicts that had been predicted taken |
| cnt_ntkn_wrong | output | CNT_W | Mispredicts that had been predicted not taken |
| cnt_mispred | output | CNT_W | Total mispredicts |

## Verification
Two kinds of collision matter. The first is several causes meeting on one thread in one cycle: a mispredict on a lane while a violation is pending and a load is blocked. The second is a violation arriving in the same cycle as a pending one is consumed. Directed cycles set up each overlap, in several lane orders, and check which lane wins, which restart PC and self-inclusion rule apply, and whether the violation stays pending. This is judged from the squash a later cycle produces or does not produce. A behavioural per-thread model then compares every output on every clock under random mixes of all causes across both threads.

// File: rtl/exec_redirect_gen.sv
module exec_redirect_gen #(
  parameter int THREADS    = 2,
  parameter int LANES      = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         lane_vld,
  input  logic [LANES-1:0]         lane_mispred,
  input  logic [LANES-1:0]         lane_pred_tkn,
  input  logic [LANES-1:0]         lane_is_load,
  input  logic [LANES*TID_W-1:0]   lane_tid,
  input  logic [LANES*PC_W-1:0]    lane_pc,
  input  logic [LANES*PC_W-1:0]    lane_npc,
  input  logic [LANES*SEQ_W-1:0]   lane_seq,
  input  logic [THREADS-1:0]       viol_set,
  input  logic [THREADS-1:0]       ld_blocked,
  input  logic [THREADS-1:0]       ld_handled,
  output logic [THREADS-1:0]       sq_vld,
  output logic [THREADS*SEQ_W-1:0] sq_seq,
  output logic [THREADS*PC_W-1:0]  sq_restart_pc,
  output logic [THREADS*PC_W-1:0]  sq_mis_pc,
  output logic [THREADS-1:0]       sq_taken,
  output logic [THREADS-1:0]       sq_incl_self,
  output logic [THREADS-1:0]       ld_handled_set,
  output logic [CNT_W-1:0]         cnt_tkn_wrong,
  output logic [CNT_W-1:0]         cnt_ntkn_wrong,
  output logic [CNT_W-1:0]         cnt_mispred
);

  logic [THREADS-1:0]            viol_q, vclr;
  logic [THREADS-1:0]            done, n_tk, n_inc, n_hs;
  logic [THREADS-1:0][SEQ_W-1:0] n_seq, seq_q;
  logic [THREADS-1:0][PC_W-1:0]  n_rpc, n_mpc, rpc_q, mpc_q;
  logic [THREADS-1:0]            vld_q, tk_q, inc_q, hs_q;
  logic [CNT_W-1:0]              tk_add, nt_add, tk_q2, nt_q2;
  logic [TID_W-1:0]              tid;
  logic [PC_W-1:0]               pc, npc;
  logic [SEQ_W-1:0]              sq;

  always_comb begin
    done = '0; n_tk = '0; n_inc = '0; n_hs = '0; vclr = '0;
    n_seq = '0; n_rpc = '0; n_mpc = '0;
    tk_add = '0; nt_add = '0;
    tid = '0; pc = '0; npc = '0; sq = '0;
    for (int l = 0; l < LANES; l++) begin
      tid = lane_tid[l*TID_W +: TID_W];
      pc  = lane_pc[l*PC_W +: PC_W];
      npc = lane_npc[l*PC_W +: PC_W];
      sq  = lane_seq[l*SEQ_W +: SEQ_W];
      if (lane_vld[l] && !done[tid]) begin
        if (lane_mispred[l]) begin
          done[tid]  = 1'b1;
          n_seq[tid] = sq;
          n_rpc[tid] = npc;
          n_mpc[tid] = pc;
          n_tk[tid]  = (npc != pc + PC_W'(INST_BYTES));
          if (lane_pred_tkn[l]) tk_add = tk_add + CNT_W'(1);
          else                  nt_add = nt_add + CNT_W'(1);
        end else if (viol_q[tid]) begin
          done[tid]  = 1'b1;
          vclr[tid]  = 1'b1;
          n_seq[tid] = sq;
          n_rpc[tid] = npc;
          n_mpc[tid] = pc;
        end else if (lane_is_load[l] && ld_blocked[tid] && !ld_handled[tid]) begin
          done[tid]  = 1'b1;
          n_seq[tid] = sq;
          n_rpc[tid] = pc;
          n_mpc[tid] = pc;
          n_inc[tid] = 1'b1;
          n_hs[tid]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q <= '0; vld_q <= '0; tk_q <= '0; inc_q <= '0; hs_q <= '0;
      seq_q  <= '0; rpc_q <= '0; mpc_q <= '0;
      tk_q2  <= '0; nt_q2 <= '0;
    end else begin
      viol_q <= (viol_q & ~vclr) | viol_set;
      vld_q  <= done;
      tk_q   <= n_tk;
      inc_q  <= n_inc;
      hs_q   <= n_hs;
      seq_q  <= n_seq;
      rpc_q  <= n_rpc;
      mpc_q  <= n_mpc;
      tk_q2  <= tk_q2 + tk_add;
      nt_q2  <= nt_q2 + nt_add;
    end
  end

  assign sq_vld         = vld_q;
  assign sq_seq         = seq_q;
  assign sq_restart_pc  = rpc_q;
  assign sq_mis_pc      = mpc_q;
  assign sq_taken       = tk_q;
  assign sq_incl_self   = inc_q;
  assign ld_handled_set = hs_q;
  assign cnt_tkn_wrong  = tk_q2;
  assign cnt_ntkn_wrong = nt_q2;
  assign cnt_mispred    = tk_q2 + nt_q2;

endmodule

module exec_redirect_gen_chk #(
  parameter int THREADS = 2,
  parameter int PC_W    = 32,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [THREADS-1:0]       sq_vld,
  input logic [THREADS*SEQ_W-1:0] sq_seq,
  input logic [THREADS*PC_W-1:0]  sq_restart_pc,
  input logic [THREADS*PC_W-1:0]  sq_mis_pc,
  input logic [THREADS-1:0]       sq_taken,
  input logic [THREADS-1:0]       sq_incl_self,
  input logic [THREADS-1:0]       ld_handled_set,
  input logic [CNT_W-1:0]         cnt_tkn_wrong,
  input logic [CNT_W-1:0]         cnt_ntkn_wrong
);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (sq_vld == '0 && cnt_tkn_wrong == '0 && cnt_ntkn_wrong == '0));

  a_r8_step_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cnt_tkn_wrong - $past(cnt_tkn_wrong)) <= CNT_W'(THREADS)));

  a_r8_needs_squash: assert property (@(posedge clk) disable iff (rst)
    (cnt_tkn_wrong != $past(cnt_tkn_wrong) || cnt_ntkn_wrong != $past(cnt_ntkn_wrong)) |-> (sq_vld != '0));

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    a_r5_self_restart: assert property (@(posedge clk) disable iff (rst)
      (sq_vld[t] && sq_incl_self[t]) |-> (sq_restart_pc[t*PC_W +: PC_W] == sq_mis_pc[t*PC_W +: PC_W]));
    a_r5_handle_pulse: assert property (@(posedge clk) disable iff (rst)
      ld_handled_set[t] |-> (sq_vld[t] && sq_incl_self[t]));
    a_r3_taken_branch_only: assert property (@(posedge clk) disable iff (rst)
      sq_taken[t] |-> (sq_vld[t] && !sq_incl_self[t]));
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !sq_vld[t] |-> (!sq_incl_self[t] && !ld_handled_set[t] && sq_seq[t*SEQ_W +: SEQ_W] == '0));
  end

endmodule

bind exec_redirect_gen exec_redirect_gen_chk #(
  .THREADS(THREADS), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .sq_vld(sq_vld), .sq_seq(sq_seq),
  .sq_restart_pc(sq_restart_pc), .sq_mis_pc(sq_mis_pc), .sq_taken(sq_taken),
  .sq_incl_self(sq_incl_self), .ld_handled_set(ld_handled_set),
  .cnt_tkn_wrong(cnt_tkn_wrong), .cnt_ntkn_wrong(cnt_ntkn_wrong)
);

// File: tb/tb_exec_redirect_gen.sv
module tb_exec_redirect_gen;
  localparam int T = 2, L = 4, PW = 32, SW = 16, CW = 16, TW = 1;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [L-1:0]    lane_vld = '0, lane_mispred = '0, lane_pred_tkn = '0, lane_is_load = '0;
  logic [L*TW-1:0] lane_tid = '0;
  logic [L*PW-1:0] lane_pc = '0, lane_npc = '0;
  logic [L*SW-1:0] lane_seq = '0;
  logic [T-1:0]    viol_set = '0, ld_blocked = '0, ld_handled = '0;
  logic [T-1:0]    sq_vld, sq_taken, sq_incl_self, ld_handled_set;
  logic [T*SW-1:0] sq_seq;
  logic [T*PW-1:0] sq_restart_pc, sq_mis_pc;
  logic [CW-1:0]   cnt_tkn_wrong, cnt_ntkn_wrong, cnt_mispred;

  exec_redirect_gen dut (.*);

  int checks = 0, fails = 0;
  bit pend [T];
  int e_vld [T], e_seq [T], e_rpc [T], e_mpc [T], e_tk [T], e_inc [T], e_cause [T];
  int e_ctk = 0, e_cnt = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string ctag(int c);
    case (c)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic model();
    bit nset [T];
    for (int t = 0; t < T; t++) begin
      e_vld[t] = 0; e_seq[t] = 0; e_rpc[t] = 0; e_mpc[t] = 0; e_tk[t] = 0; e_inc[t] = 0; e_cause[t] = 0;
      nset[t] = pend[t];
      for (int l = 0; l < L; l++) begin
        if (lane_vld[l] && int'(lane_tid[l]) == t) begin
          int pc  = int'(lane_pc[l*PW +: PW]);
          int npc = int'(lane_npc[l*PW +: PW]);
          int c = 0;
          if (lane_mispred[l]) c = 1;
          else if (pend[t]) c = 2;
          else if (lane_is_load[l] && ld_blocked[t] && !ld_handled[t]) c = 3;
          if (c != 0) begin
            e_vld[t] = 1; e_cause[t] = c;
            e_seq[t] = int'(lane_seq[l*SW +: SW]);
            e_mpc[t] = pc;
            e_rpc[t] = (c == 3) ? pc : npc;
            e_inc[t] = (c == 3);
            if (c == 1) begin
              e_tk[t] = (npc != pc + 4);
              if (lane_pred_tkn[l]) e_ctk++; else e_cnt++;
            end
            if (c == 2) nset[t] = 0;
            break;
          end
        end
      end
      pend[t] = nset[t] | viol_set[t];
    end
  endtask

  task automatic compare();
    for (int t = 0; t < T; t++) begin
      bit ok;
      ok = sq_vld[t] == e_vld[t][0] && int'(sq_seq[t*SW +: SW]) == e_seq[t]
        && int'(sq_restart_pc[t*PW +: PW]) == e_rpc[t] && int'(sq_mis_pc[t*PW +: PW]) == e_mpc[t]
        && sq_taken[t] == e_tk[t][0] && sq_incl_self[t] == e_inc[t][0]
        && ld_handled_set[t] == (e_cause[t] == 3);
      chk(ok, ctag(e_cause[t]), {sq_vld[t], sq_seq[t*SW +: SW], sq_restart_pc[t*PW +: PW]},
          {e_vld[t][0], e_seq[t][SW-1:0], e_rpc[t]});
    end
    chk(int'(cnt_tkn_wrong) == e_ctk && int'(cnt_ntkn_wrong) == e_cnt
        && int'(cnt_mispred) == e_ctk + e_cnt, "R8", {cnt_tkn_wrong, cnt_ntkn_wrong}, {e_ctk[15:0], e_cnt[15:0]});
  endtask

  task automatic cycle();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic clr();
    lane_vld = '0; lane_mispred = '0; lane_pred_tkn = '0; lane_is_load = '0;
    viol_set = '0;
  endtask

  task automatic lane(int l, int tid, bit mis, bit ptk, bit ld, int pc, int npc, int seq);
    lane_vld[l] = 1; lane_tid[l] = tid[0]; lane_mispred[l] = mis; lane_pred_tkn[l] = ptk;
    lane_is_load[l] = ld; lane_pc[l*PW +: PW] = pc; lane_npc[l*PW +: PW] = npc;
    lane_seq[l*SW +: SW] = seq[SW-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int t = 0; t < T; t++) pend[t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(sq_vld == '0 && cnt_mispred == '0 && sq_incl_self == '0, "R1", sq_vld, 0);
    rst = 0;
    cycle();
    chk(sq_vld == '0, "R1", sq_vld, 0);

    // R2/R3: mispredict taken branch on thread 0
    clr(); lane(1, 0, 1, 0, 0, 'h100, 'h200, 11); cycle();
    chk(sq_taken[0] == 1 && sq_restart_pc[PW-1:0] == 'h200, "R3", sq_taken[0], 1);
    // R3: not-taken resolution, predicted taken
    clr(); lane(0, 1, 1, 1, 0, 'h300, 'h304, 12); cycle();
    chk(sq_taken[1] == 0 && sq_mis_pc[PW +: PW] == 'h300, "R3", sq_taken[1], 0);
    // R10: message lasts one cycle
    clr(); cycle();
    chk(sq_vld == '0, "R10", sq_vld, 0);

    // R6: two mispredicts same thread; oldest wins, counter +1 only
    clr(); lane(0, 0, 1, 1, 0, 'h10, 'h40, 21); lane(2, 0, 1, 1, 0, 'h20, 'h80, 22); cycle();
    chk(sq_seq[SW-1:0] == 21, "R6", sq_seq[SW-1:0], 21);

    // R4: violation pending then consumed; second cycle sees no squash
    clr(); viol_set[0] = 1; cycle();
    clr(); lane(0, 0, 0, 0, 0, 'h500, 'h504, 31); cycle();
    chk(sq_vld[0] && !sq_incl_self[0] && sq_restart_pc[PW-1:0] == 'h504, "R4", sq_restart_pc[PW-1:0], 'h504);
    clr(); lane(0, 0, 0, 0, 0, 'h600, 'h604, 32); cycle();
    chk(sq_vld[0] == 0, "R4", sq_vld[0], 0);

    // R7: mispredict beats pending violation; violation stays pending
    clr(); viol_set[1] = 1; cycle();
    clr(); lane(0, 1, 1, 0, 0, 'h700, 'h704, 41); cycle();
    chk(sq_restart_pc[PW +: PW] == 'h704 && !sq_incl_self[1], "R7", sq_seq[SW +: SW], 41);
    clr(); lane(0, 1, 0, 0, 0, 'h800, 'h808, 42); cycle();
    chk(sq_vld[1] && sq_seq[SW +: SW] == 42, "R7", sq_seq[SW +: SW], 42);
    // R4: violation arriving while one is consumed stays pending
    clr(); viol_set[0] = 1; cycle();
    clr(); viol_set[0] = 1; lane(0, 0, 0, 0, 0, 'h900, 'h904, 43); cycle();
    clr(); lane(3, 0, 0, 0, 0, 'hA00, 'hA04, 44); cycle();
    chk(sq_vld[0] && sq_seq[SW-1:0] == 44, "R4", sq_seq[SW-1:0], 44);

    // R5: blocked load includes itself, restarts at own PC
    clr(); ld_blocked = 2'b10; lane(0, 1, 0, 0, 0, 'hB00, 'hB04, 51); lane(1, 1, 0, 0, 1, 'hB10, 'hB14, 52); cycle();
    chk(sq_incl_self[1] && ld_handled_set[1] && sq_restart_pc[PW +: PW] == 'hB10, "R5", sq_restart_pc[PW +: PW], 'hB10);
    clr(); ld_handled = 2'b10; lane(0, 1, 0, 0, 1, 'hC00, 'hC04, 53); cycle();
    chk(sq_vld[1] == 0, "R5", sq_vld[1], 0);
    ld_blocked = '0; ld_handled = '0;

    // R9 + R11: both threads at once; invalid lane carries a mispredict
    clr(); lane(0, 0, 1, 0, 0, 'hD00, 'hD04, 61); lane(1, 1, 1, 1, 0, 'hE00, 'hF00, 62);
    lane_vld[1] = 0; lane(2, 1, 1, 0, 0, 'hE40, 'hE44, 63); cycle();
    chk(sq_vld == 2'b11 && sq_seq[SW +: SW] == 63, "R9", sq_seq[SW +: SW], 63);
    clr(); lane_mispred = '1; cycle();
    chk(sq_vld == '0, "R11", sq_vld, 0);

    // random mix, all requirements compared every clock
    for (int n = 0; n < 3000; n++) begin
      clr();
      for (int l = 0; l < L; l++) begin
        int pc;
        pc = int'($urandom_range(0, 255)) * 4;
        if ($urandom_range(0, 3) != 0)
          lane(l, int'($urandom_range(0, 1)), $urandom_range(0, 7) == 0, 1'($urandom),
               $urandom_range(0, 2) == 0, pc,
               ($urandom_range(0, 1) != 0) ? pc + 4 : int'($urandom_range(0, 255)) * 4,
               int'($urandom_range(0, 65535)));
      end
      for (int t = 0; t < T; t++) begin
        viol_set[t]   = $urandom_range(0, 9) == 0;
        ld_blocked[t] = $urandom_range(0, 3) == 0;
        ld_handled[t] = $urandom_range(0, 1) == 0;
      end
      cycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule